// File: doc/BRIEF.md
# Multiplexed LCD Drive Sequencer

This block produces the frame timing and the per-pin drive codes for a multiplexed segment display. It runs in one of two arrangements: four commons with twenty segments (quarter duty, third bias) or eight commons with sixteen segments (eighth duty, quarter bias). In the eight-common arrangement, the four highest segment pins become commons. Every frame has a fixed length in clocks. That length is split into a display period, which is divided into one slot per common, and a trailing key-scan window whose length is programmable. During the key-scan window the segment pins are released to inputs so that a neighbouring keyscan block can sample them. That block keeps in step through a one-cycle frame-start pulse and a scan-window level.

Pixel data comes from a 16-word by 8-bit display memory through a synchronous read port. The block sweeps that port one word per clock into a local shadow copy, so the pins always reflect recent memory contents and no request handshake is needed. Analog bias generation is outside the block. Each pin gets a 3-bit level code that counts in units of supply/B, where B is the bias divisor (3 or 4). Code 0 is ground and code B is the supply.

Top module: `lcd_mux_sequencer`

## Requirements
- R1: When not in standby, `frame_start` pulses for one cycle when the frame counter is 0. A frame lasts 110 clocks with four commons and 55 clocks with eight commons.
- R2: `scan_window` is high for the last S clocks of each frame. With `scan_code` = c, S = 2c+2 with four commons and S = 2c+1 with eight commons. The display period is D = frame length − S.
- R3: The display period is divided into N slots (N = 4 or 8), each floor(D/N) clocks long. Any leftover clocks go to the last slot. Common j is selected during slot j.
- R4: Level codes use p = frame polarity, which starts at 0 after reset and flips at every frame end. With p=0, a selected common takes B, an unselected common takes 1, an on segment takes 0 and an off segment takes 2. With p=1, every code v becomes B−v. B is 3 with four commons and 4 with eight commons.
- R5: With four commons, segment pin s takes its data from word s/2. Even pins use bits 3..0 and odd pins use bits 7..4. Within the nibble, bit k is the common-k data. A 1 means on.
- R6: With eight commons, segment pin s (0..15) takes its data from word s, and bit k is the common-k data.
- R7: With eight commons, pins 16, 17, 18 and 19 of `seg_lvl` drive commons 7, 6, 5 and 4. Their `seg_in` bit is 0.
- R8: During the scan window, every segment-role pin has `seg_in`=1 and level 0, and every common-role pin has level 0.
- R9: When `disp_on`=0, all commons are at level 0 and all segment-role pins are inputs at level 0. Frame timing continues.
- R10: While `standby`=1, the frame counter is held at 0, `frame_start` and `scan_window` stay low, polarity is held, and the pins behave as in R9.
- R11: `mode_8com` and `scan_code` are taken at each frame end and while in standby. They hold for the whole frame. After reset the block is in four-common mode with code 0.
- R12: `mem_addr` advances by one every clock (modulo 16). A memory change reaches the pins within 20 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_on | input | 1 | Display enable |
| standby | input | 1 | Standby: freezes timing, blanks pins |
| mode_8com | input | 1 | 1 selects eight commons, 0 selects four |
| scan_code | input | 3 | Key-scan window length code |
| mem_addr | output | 4 | Display memory read address |
| mem_rdata | input | 8 | Read data, valid one clock after the address |
| frame_start | output | 1 | One-cycle pulse at frame count 0 |
| scan_window | output | 1 | High during the key-scan window |
| com_lvl | output | 12 | Level codes for commons 0..3, 3 bits each |
| seg_lvl | output | 60 | Level codes for pins 0..19, 3 bits each |
| seg_in | output | 20 | 1 when the pin is released to input |

## Verification
All pin outputs are combinational decodes of registered state. A configuration or timing change sampled at a clock edge therefore shows at the pins in that same cycle, and the bench samples at the falling edge. Mode and code changes take effect only on the cycle after a frame end, so the bench's reference frame counter latches them at the same point. Memory writes take up to about 18 clocks to reach a pin through the sweep and the shadow copy. The bench therefore skips data-dependent segment comparisons for 24 clocks after each write. Timing, common levels and input releases are still compared on every cycle.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
   localparam int LVL_W = 3;
   typedef logic [LVL_W-1:0] lvl_t;

   localparam lvl_t V_COM_IDLE = lvl_t'(1);
   localparam lvl_t V_SEG_ON   = lvl_t'(0);
   localparam lvl_t V_SEG_OFF  = lvl_t'(2);

   // mirror a code about mid-rail on odd frames
   function automatic lvl_t drive_lvl(input lvl_t v, input logic pol, input lvl_t top);
      return pol ? lvl_t'(top - v) : v;
   endfunction
endpackage

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer #(
   parameter int FRAME4_CLKS = 110,
   parameter int FRAME8_CLKS = 55
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       standby,
   input  logic       mode8_in,
   input  logic [2:0] code_in,
   output logic       mode8_q,
   output logic [2:0] slot,
   output logic       pol,
   output logic       frame_start,
   output logic       scan_window
);
   localparam int FRAME_MAX = (FRAME4_CLKS > FRAME8_CLKS) ? FRAME4_CLKS : FRAME8_CLKS;
   localparam int CNT_W     = $clog2(FRAME_MAX + 1);

   logic [2:0]       code_q;
   logic [CNT_W-1:0] cnt, in_slot;
   logic [CNT_W-1:0] frame_len, scan_len, disp_len, slot_len;
   logic [2:0]       last_slot;
   logic             running, wrap;

   assign running   = !standby;
   assign frame_len = mode8_q ? CNT_W'(FRAME8_CLKS) : CNT_W'(FRAME4_CLKS);
   assign scan_len  = mode8_q ? CNT_W'(2 * code_q + 1) : CNT_W'(2 * code_q + 2);
   assign disp_len  = frame_len - scan_len;
   assign slot_len  = mode8_q ? (disp_len >> 3) : (disp_len >> 2);
   assign last_slot = mode8_q ? 3'd7 : 3'd3;
   assign wrap      = running && (cnt == frame_len - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         in_slot <= '0;
         slot    <= '0;
         pol     <= 1'b0;
         mode8_q <= 1'b0;
         code_q  <= 3'd0;
      end else if (!running) begin
         cnt     <= '0;
         in_slot <= '0;
         slot    <= '0;
         mode8_q <= mode8_in;
         code_q  <= code_in;
      end else if (wrap) begin
         cnt     <= '0;
         in_slot <= '0;
         slot    <= '0;
         pol     <= ~pol;
         mode8_q <= mode8_in;
         code_q  <= code_in;
      end else begin
         cnt <= cnt + 1'b1;
         if ((in_slot == slot_len - 1'b1) && (slot != last_slot)) begin
            slot    <= slot + 1'b1;
            in_slot <= '0;
         end else begin
            in_slot <= in_slot + 1'b1;
         end
      end
   end

   assign frame_start = running && (cnt == '0);
   assign scan_window = running && (cnt >= disp_len);

   a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n) cnt < frame_len);
   a_r1_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n) wrap |=> cnt == '0);
   a_r3_slot_bound: assert property (@(posedge clk) disable iff (!rst_n) slot <= last_slot);
   a_r4_pol_flip: assert property (@(posedge clk) disable iff (!rst_n) wrap |=> pol != $past(pol));
   a_r10_standby_hold: assert property (@(posedge clk) disable iff (!rst_n)
      standby |=> (cnt == '0) && $stable(pol));
   a_r11_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !wrap) |=> $stable(mode8_q) && $stable(code_q));
endmodule

// File: rtl/lcd_shadow_fetch.sv
module lcd_shadow_fetch #(
   parameter int NWORD  = 16,
   parameter int WORD_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   output logic [$clog2(NWORD)-1:0]  mem_addr,
   input  logic [WORD_W-1:0]         mem_rdata,
   output logic [NWORD*WORD_W-1:0]   shadow_flat
);
   localparam int ADDR_W = $clog2(NWORD);

   logic [ADDR_W-1:0]             ptr, ptr_q;
   logic                          vld_q;
   logic [NWORD-1:0][WORD_W-1:0]  shadow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr    <= '0;
         ptr_q  <= '0;
         vld_q  <= 1'b0;
         shadow <= '0;
      end else begin
         ptr   <= ptr + 1'b1;
         ptr_q <= ptr;
         vld_q <= 1'b1;
         if (vld_q) shadow[ptr_q] <= mem_rdata;
      end
   end

   assign mem_addr    = ptr;
   assign shadow_flat = shadow;

   a_r12_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |=> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));
endmodule

// File: rtl/lcd_pin_encoder.sv
module lcd_pin_encoder
   import lcd_seq_pkg::*;
#(
   parameter int NWORD  = 16,
   parameter int WORD_W = 8,
   parameter int NSEG   = 20,
   parameter int NCOM   = 4
) (
   input  logic                    quiet,
   input  logic                    mode8,
   input  logic [2:0]              slot,
   input  logic                    pol,
   input  logic [NWORD*WORD_W-1:0] shadow_flat,
   output logic [NCOM*LVL_W-1:0]   com_lvl,
   output logic [NSEG*LVL_W-1:0]   seg_lvl,
   output logic [NSEG-1:0]         seg_in
);
   localparam int DUAL_LO = NSEG - NCOM;

   lvl_t top;
   assign top = mode8 ? lvl_t'(4) : lvl_t'(3);

   for (genvar j = 0; j < NCOM; j++) begin : g_com
      lvl_t v;
      assign v = (slot == 3'(j)) ? top : V_COM_IDLE;
      assign com_lvl[j*LVL_W +: LVL_W] = quiet ? '0 : drive_lvl(v, pol, top);
   end

   for (genvar s = 0; s < NSEG; s++) begin : g_seg
      logic [WORD_W-1:0] w4;
      logic [3:0]        nib;
      logic              bit4, on;
      lvl_t              seg_v;
      assign w4    = shadow_flat[(s/2)*WORD_W +: WORD_W];
      assign nib   = w4[(s%2)*4 +: 4];
      assign bit4  = nib[slot[1:0]];
      assign seg_v = on ? V_SEG_ON : V_SEG_OFF;

      if (s >= DUAL_LO) begin : g_dual
         lvl_t cv;
         assign on = bit4;
         assign cv = (slot == 3'(NSEG + NCOM - 1 - s)) ? top : V_COM_IDLE;
         always_comb begin
            if (mode8) begin
               seg_in[s]                 = 1'b0;
               seg_lvl[s*LVL_W +: LVL_W] = quiet ? '0 : drive_lvl(cv, pol, top);
            end else begin
               seg_in[s]                 = quiet;
               seg_lvl[s*LVL_W +: LVL_W] = quiet ? '0 : drive_lvl(seg_v, pol, top);
            end
         end
      end else begin : g_plain
         logic [WORD_W-1:0] w8;
         assign w8 = shadow_flat[s*WORD_W +: WORD_W];
         assign on = mode8 ? w8[slot] : bit4;
         assign seg_in[s]                 = quiet;
         assign seg_lvl[s*LVL_W +: LVL_W] = quiet ? '0 : drive_lvl(seg_v, pol, top);
      end
   end
endmodule

// File: rtl/lcd_mux_sequencer.sv
module lcd_mux_sequencer
   import lcd_seq_pkg::*;
#(
   parameter int FRAME4_CLKS = 110,
   parameter int FRAME8_CLKS = 55,
   parameter int NWORD       = 16,
   parameter int WORD_W      = 8,
   parameter int NSEG        = 20,
   parameter int NCOM        = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     disp_on,
   input  logic                     standby,
   input  logic                     mode_8com,
   input  logic [2:0]               scan_code,
   output logic [$clog2(NWORD)-1:0] mem_addr,
   input  logic [WORD_W-1:0]        mem_rdata,
   output logic                     frame_start,
   output logic                     scan_window,
   output logic [NCOM*LVL_W-1:0]    com_lvl,
   output logic [NSEG*LVL_W-1:0]    seg_lvl,
   output logic [NSEG-1:0]          seg_in
);
   if (NWORD != 16 || WORD_W != 8 || NSEG != 20 || NCOM != 4) begin : g_bad_geom
      $error("pin mapping needs 16x8 memory, 20 segment pins, 4 common pins");
   end
   if (FRAME4_CLKS - 16 < 4 || FRAME8_CLKS - 15 < 8) begin : g_bad_frame
      $error("frame too short for the longest scan window");
   end
   if (LVL_W < 3) begin : g_bad_lvl
      $error("level code must hold value 4");
   end

   logic                    mode8, pol, quiet;
   logic [2:0]              slot;
   logic [NWORD*WORD_W-1:0] shadow_flat;

   lcd_frame_timer #(.FRAME4_CLKS(FRAME4_CLKS), .FRAME8_CLKS(FRAME8_CLKS)) timer_i (
      .clk(clk), .rst_n(rst_n), .standby(standby), .mode8_in(mode_8com),
      .code_in(scan_code), .mode8_q(mode8), .slot(slot), .pol(pol),
      .frame_start(frame_start), .scan_window(scan_window)
   );

   lcd_shadow_fetch #(.NWORD(NWORD), .WORD_W(WORD_W)) fetch_i (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .shadow_flat(shadow_flat)
   );

   assign quiet = !disp_on || standby || scan_window;

   lcd_pin_encoder #(.NWORD(NWORD), .WORD_W(WORD_W), .NSEG(NSEG), .NCOM(NCOM)) enc_i (
      .quiet(quiet), .mode8(mode8), .slot(slot), .pol(pol), .shadow_flat(shadow_flat),
      .com_lvl(com_lvl), .seg_lvl(seg_lvl), .seg_in(seg_in)
   );

   a_r7_dual_role: assert property (@(posedge clk) disable iff (!rst_n)
      mode8 |-> seg_in[NSEG-1:NSEG-NCOM] == '0);
   a_r8_scan_release: assert property (@(posedge clk) disable iff (!rst_n)
      scan_window |-> (com_lvl == '0) && (&seg_in[NSEG-NCOM-1:0]));
   a_r9_blank_pins: assert property (@(posedge clk) disable iff (!rst_n)
      (!disp_on || standby) |-> (com_lvl == '0) && (seg_lvl == '0));
   a_r10_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      standby |-> !frame_start && !scan_window);
endmodule

// File: tb/lcd_mux_sequencer_tb.sv
module lcd_mux_sequencer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        disp_on = 1'b0, standby = 1'b0, mode_8com = 1'b0;
   logic [2:0]  scan_code = 3'd0;
   logic [3:0]  mem_addr;
   logic [7:0]  mem_rdata;
   logic        frame_start, scan_window;
   logic [11:0] com_lvl;
   logic [59:0] seg_lvl;
   logic [19:0] seg_in;

   int n_vec = 0, n_bad = 0;
   bit done = 1'b0;
   int since_write = 0;
   logic [7:0] mem [16];

   always #4 clk = ~clk;

   lcd_mux_sequencer dut_i (
      .clk(clk), .rst_n(rst_n), .disp_on(disp_on), .standby(standby),
      .mode_8com(mode_8com), .scan_code(scan_code), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .frame_start(frame_start), .scan_window(scan_window),
      .com_lvl(com_lvl), .seg_lvl(seg_lvl), .seg_in(seg_in)
   );

   always @(posedge clk) mem_rdata <= mem[mem_addr];

   // reference frame model from the requirements
   logic       m_mode8, m_pol;
   logic [2:0] m_code;
   int         m_cnt;
   logic [3:0] m_addr;

   function automatic int flen(input logic m8);
      return m8 ? 55 : 110;
   endfunction
   function automatic int dlen(input logic m8, input logic [2:0] c);
      return flen(m8) - (m8 ? 2*c + 1 : 2*c + 2);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt <= 0; m_pol <= 1'b0; m_mode8 <= 1'b0; m_code <= 3'd0; m_addr <= 4'd0;
      end else begin
         m_addr <= m_addr + 4'd1;
         if (standby) begin
            m_cnt <= 0; m_mode8 <= mode_8com; m_code <= scan_code;
         end else if (m_cnt == flen(m_mode8) - 1) begin
            m_cnt <= 0; m_pol <= ~m_pol; m_mode8 <= mode_8com; m_code <= scan_code;
         end else begin
            m_cnt <= m_cnt + 1;
         end
      end
   end

   // R4: code v becomes B-v on odd frames
   function automatic logic [2:0] lv(input int v, input int b, input logic p);
      return p ? 3'(b - v) : 3'(v);
   endfunction

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h (t=%0t)", tag, got, exp, $time);
      end
   endtask

   bit mon_en = 1'b0;
   always @(negedge clk) begin
      if (rst_n) since_write <= since_write + 1;
      if (mon_en && rst_n) begin
         automatic int d = dlen(m_mode8, m_code);
         automatic int nc = m_mode8 ? 8 : 4;
         automatic int sl = d / nc;
         automatic int slot = (m_cnt / sl > nc - 1) ? nc - 1 : m_cnt / sl;
         automatic int b = m_mode8 ? 4 : 3;
         automatic logic run = !standby;
         automatic logic e_fs = run && (m_cnt == 0);
         automatic logic e_sw = run && (m_cnt >= d);
         automatic logic blank = !disp_on || standby;
         automatic logic quiet = blank || e_sw;
         automatic logic [11:0] e_com;
         automatic logic [59:0] e_seg;
         automatic logic [19:0] e_in;
         automatic logic [19:0] data_mask = '0;
         automatic string ttag = standby ? "R10" :
            ((m_mode8 !== mode_8com || m_code !== scan_code) ? "R11" : "R1");
         for (int j = 0; j < 4; j++)
            e_com[j*3 +: 3] = quiet ? 3'd0 : lv((slot == j) ? b : 1, b, m_pol);
         for (int s = 0; s < 20; s++) begin
            if (m_mode8 && s >= 16) begin
               e_in[s] = 1'b0;
               e_seg[s*3 +: 3] = quiet ? 3'd0 : lv((slot == 23 - s) ? b : 1, b, m_pol);
            end else begin
               automatic logic bt = m_mode8 ? mem[s][slot] : mem[s/2][(s%2)*4 + slot];
               e_in[s] = quiet;
               e_seg[s*3 +: 3] = quiet ? 3'd0 : lv(bt ? 0 : 2, b, m_pol);
               if (!quiet) data_mask[s] = 1'b1;
            end
         end
         chk(ttag, 64'(frame_start), 64'(e_fs));
         chk(standby ? "R10" : "R2", 64'(scan_window), 64'(e_sw));
         chk(blank ? "R9" : (m_pol ? "R4" : "R3"), 64'(com_lvl), 64'(e_com));
         chk(blank ? "R9" : "R8", 64'(seg_in), 64'(e_in));
         chk("R12", 64'(mem_addr), 64'(m_addr));
         if (m_mode8)
            chk("R7", 64'(seg_lvl[59:48]), 64'(e_seg[59:48]));
         if (since_write > 24) begin
            for (int s = 0; s < 20; s++)
               if (data_mask[s] || quiet)
                  chk(m_mode8 ? "R6" : "R5", 64'(seg_lvl[s*3 +: 3]), 64'(e_seg[s*3 +: 3]));
         end
      end
   end

   // {mode8, code[2:0], disp_on, standby, cycles[9:0]}
   localparam logic [15:0] STEPS [10] = '{
      {1'b0, 3'd0, 1'b1, 1'b0, 10'd250},
      {1'b0, 3'd7, 1'b1, 1'b0, 10'd300},
      {1'b1, 3'd0, 1'b1, 1'b0, 10'd200},
      {1'b1, 3'd7, 1'b1, 1'b0, 10'd150},
      {1'b1, 3'd3, 1'b0, 1'b0, 10'd120},
      {1'b1, 3'd3, 1'b1, 1'b1, 10'd60},
      {1'b0, 3'd3, 1'b1, 1'b0, 10'd230},
      {1'b0, 3'd5, 1'b1, 1'b1, 10'd40},
      {1'b1, 3'd5, 1'b1, 1'b0, 10'd170},
      {1'b0, 3'd2, 1'b1, 1'b0, 10'd333}
   };

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = 8'((i * 37 + 5) ^ (i << 4));
      repeat (3) @(negedge clk);
      // reset state: R1 pulse at count 0, R9 blank pins
      chk("R1", 64'(frame_start), 64'd1);
      chk("R9", 64'(seg_in), 64'hFFFFF);
      chk("R9", 64'(com_lvl), 64'd0);
      #1 rst_n = 1'b1;
      since_write = 0;
      @(negedge clk);
      chk("R11", 64'(scan_window), 64'd0);
      mon_en = 1'b1;
      for (int k = 0; k < 10; k++) begin
         #1;
         {mode_8com, scan_code, disp_on, standby} = STEPS[k][15:10];
         repeat (int'(STEPS[k][9:0])) @(negedge clk);
      end
      // R12: rewrite memory, data must reach the pins
      #1;
      for (int i = 0; i < 16; i++) mem[i] = ~mem[i] ^ 8'(i);
      since_write = 0;
      {mode_8com, scan_code, disp_on, standby} = {1'b1, 3'd1, 1'b1, 1'b0};
      repeat (220) @(negedge clk);
      #1;
      for (int i = 0; i < 16; i++) mem[i] = 8'(i * 17);
      since_write = 0;
      {mode_8com, scan_code, disp_on, standby} = {1'b0, 3'd6, 1'b1, 1'b0};
      repeat (350) @(negedge clk);
      mon_en = 1'b0;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule